// File: doc/BRIEF.md
# Keypad Interrupt and Key-Code Interface

This peripheral watches ten active-high key lines, numbered 0 to 9, and tells a microcontroller when a key goes down. On a new press it stores the key's number, pulls an active-low interrupt request line low and holds that request until the processor reads the stored number. The interrupt service routine fetches the number over a small 8-bit read bus with a chip select, a read strobe and a register address.

The key lines are sampled on the block's clock and are assumed to be clean and already synchronous. A press is the rising edge of a key line. If several lines rise in the same cycle, the lowest-numbered one is kept. While a number is waiting to be read, further presses are dropped. Reading the code register releases the request and re-arms the block for the next press.

Top module: `kpd_irq_ctrl`

## Requirements
- R1: While and after a synchronous reset, `irq_n` is 1 and a read of the code register returns 8'h00.
- R2: When no code is waiting, a key line that changes from 0 to 1 is latched at the next rising clock edge, and `irq_n` is 0 from that edge on.
- R3: A read of the code register (address 0) while a code is waiting returns bit 7 = 1, bits 6:4 = 0 and bits 3:0 = the key number, so key 5 reads as 8'h85.
- R4: When several key lines rise in the same cycle, the lowest-numbered key is latched.
- R5: While a code is waiting, new presses of any key leave the stored number and `irq_n` unchanged.
- R6: A read of the code register (`cs` = 1, `rd` = 1, `addr` = 0) sampled at a clock edge clears the waiting code at that edge. `irq_n` returns to 1 and later reads return 8'h00 until the next press.
- R7: A read of any address other than 0 returns 8'h00 and does not clear the waiting code. A read strobe with `cs` = 0 also does not clear it.
- R8: A key held down after its code has been read is not latched again. The key must go back to 0 and then to 1 again before it is latched.
- R9: A key line that is already 1 when reset is released does not count as a press.
- R10: A key that rises in the same cycle as the clearing read is latched as the new waiting code, and `irq_n` stays 0.
- R11: `rdata` is 8'h00 whenever `cs` and `rd` are not both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_i | input | 10 | Key lines, 1 = pressed, bit n is key n |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| addr | input | 2 | Register address, 0 = code register |
| rdata | output | 8 | Read data, valid while `cs` and `rd` are both high |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is a new key edge that arrives in exactly the cycle in which the processor's clearing read is sampled. The bench reaches it by first leaving a code waiting. Then, at a single falling edge, it drives the read strobe together with a fresh rising key line, so both are seen at the same rising edge. It then checks that the new number replaces the old one and that the request never releases. Two other cases are reached the same way, by setting the key lines before a clear or before reset is released: a key held across the clear, and a key held across reset.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  // Widest key bank the shared helpers accept.
  localparam int KPD_MAX_KEYS = 16;

  // Index of the lowest set request bit. The search runs downward, so the
  // last hit it records is the smallest index. Returns 0 when nothing is set.
  function automatic int unsigned lowest_index(input logic [KPD_MAX_KEYS-1:0] req);
    int unsigned idx;
    idx = 0;
    for (int i = KPD_MAX_KEYS - 1; i >= 0; i--) begin
      if (req[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/kpd_edge_detect.sv
module kpd_edge_detect #(
  parameter int NUM_KEYS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keys,
  output logic [NUM_KEYS-1:0] rise
);

  logic [NUM_KEYS-1:0] prev_q;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    // During reset the history follows the live line, so a key that is
    // held through reset is not seen as a new press afterwards.
    always_ff @(posedge clk) begin
      prev_q[g] <= keys[g];
    end
    assign rise[g] = keys[g] & ~prev_q[g];
  end

  // R9: in the first cycle after reset, only a line that changed since the
  // reset edge can show a rise.
  assert_no_rise_from_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ((rise & ~(keys & ~$past(keys))) == '0));

  // rst is only referenced inside the assertion above.
  logic unused_rst;
  assign unused_rst = rst;

endmodule

// File: rtl/kpd_prio_enc.sv
module kpd_prio_enc
  import kpd_pkg::*;
#(
  parameter int NUM_KEYS = 10,
  parameter int CODE_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic [NUM_KEYS-1:0] req,
  output logic                any_o,
  output logic [CODE_W-1:0]   idx_o
);

  logic [KPD_MAX_KEYS-1:0] req_ext;
  logic [NUM_KEYS-1:0]     below_mask;

  always_comb begin
    req_ext                 = '0;
    req_ext[NUM_KEYS-1:0]   = req;
    any_o                   = |req;
    idx_o                   = CODE_W'(lowest_index(req_ext));
  end

  // Every bit strictly below the chosen index.
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (i < int'(idx_o)) below_mask[i] = 1'b1;
    end
  end

  // R4: the chosen key is requesting, and no lower-numbered key is.
  always_comb begin
    if (any_o) begin
      assert_lowest_wins_R4: assert (req[idx_o] && ((req & below_mask) == '0));
    end
  end

endmodule

// File: rtl/kpd_pending_reg.sv
module kpd_pending_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              press,     // some key rose this cycle
  input  logic [CODE_W-1:0] new_code,  // winner among the keys that rose
  input  logic              clear,     // processor read of the code register
  output logic              pending_o,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_n_o
);

  logic              pending_q;
  logic [CODE_W-1:0] code_q;
  logic              load;

  // A press is taken when nothing is waiting, or when the waiting code is
  // being read in this same cycle.
  assign load = press && (!pending_q || clear);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      code_q    <= '0;
    end else if (load) begin
      pending_q <= 1'b1;
      code_q    <= new_code;
    end else if (clear) begin
      pending_q <= 1'b0;
      code_q    <= '0;
    end
  end

  assign pending_o = pending_q;
  assign code_o    = code_q;
  assign irq_n_o   = ~pending_q;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (press && !pending_q) |=> (!irq_n_o && code_o == $past(new_code)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !clear) |=> ($stable(code_o) && !irq_n_o));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (clear && !press) |=> (irq_n_o && code_o == '0));

  assert_coincide_R10: assert property (@(posedge clk) disable iff (rst)
    (clear && press) |=> (!irq_n_o && code_o == $past(new_code)));

endmodule

// File: rtl/kpd_irq_ctrl.sv
module kpd_irq_ctrl #(
  parameter int                NUM_KEYS  = 10,
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 2,
  parameter int                VALID_BIT = 7,
  parameter logic [ADDR_W-1:0] CODE_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] key_i,
  input  logic                cs,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   rdata,
  output logic                irq_n
);

  localparam int CODE_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;

  // Named internal events, used by the assertions.
  logic [NUM_KEYS-1:0] key_rise;
  logic                any_rise;
  logic [CODE_W-1:0]   win_code;
  logic                code_read;
  logic                pending;
  logic [CODE_W-1:0]   held_code;

  // Status byte: the valid flag at VALID_BIT and the key number in the
  // low bits. All other bits are zero.
  function automatic logic [DATA_W-1:0] pack_status(input logic valid,
                                                    input logic [CODE_W-1:0] code);
    logic [DATA_W-1:0] s;
    s             = '0;
    s[CODE_W-1:0] = code;
    s[VALID_BIT]  = valid;
    return s;
  endfunction

  kpd_edge_detect #(.NUM_KEYS(NUM_KEYS)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .keys (key_i),
    .rise (key_rise)
  );

  kpd_prio_enc #(.NUM_KEYS(NUM_KEYS), .CODE_W(CODE_W)) u_enc (
    .req   (key_rise),
    .any_o (any_rise),
    .idx_o (win_code)
  );

  assign code_read = cs && rd && (addr == CODE_ADDR);

  kpd_pending_reg #(.CODE_W(CODE_W)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .press     (any_rise),
    .new_code  (win_code),
    .clear     (code_read),
    .pending_o (pending),
    .code_o    (held_code),
    .irq_n_o   (irq_n)
  );

  always_comb begin
    if (code_read) rdata = pack_status(pending, held_code);
    else           rdata = '0;
  end

  // R7: a read of another address, or a strobe without chip select,
  // leaves a waiting request in place.
  assert_foreign_read_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && rd && !(cs && addr == CODE_ADDR)) |=> !irq_n);

  // R3: while a code is waiting, the valid flag reads as 1 at the code address.
  assert_valid_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (code_read && !irq_n) |-> rdata[VALID_BIT]);

endmodule

// File: tb/kpd_irq_ctrl_test.sv
`timescale 1ns/100ps
module kpd_irq_ctrl_test;

  localparam int NK = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NK-1:0] key_i = '0;
  logic          cs = 1'b0;
  logic          rd = 1'b0;
  logic [1:0]    addr = '0;
  logic [7:0]    rdata;
  logic          irq_n;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  kpd_irq_ctrl uut (
    .clk(clk), .rst(rst), .key_i(key_i), .cs(cs), .rd(rd),
    .addr(addr), .rdata(rdata), .irq_n(irq_n)
  );

  // {key pattern, expected winning key}
  localparam logic [13:0] VEC [10] = '{
    {10'h001, 4'd0}, {10'h020, 4'd5}, {10'h200, 4'd9}, {10'h300, 4'd8},
    {10'h3FF, 4'd0}, {10'h220, 4'd5}, {10'h204, 4'd2}, {10'h180, 4'd7},
    {10'h010, 4'd4}, {10'h0C8, 4'd3}
  };

  // The bench's own model: scan upward and stop at the first set bit.
  function automatic logic [3:0] ref_key(input logic [NK-1:0] p);
    for (int i = 0; i < NK; i++) if (p[i]) return 4'(i);
    return 4'd0;
  endfunction

  function automatic logic [7:0] ref_byte(input logic v, input logic [3:0] k);
    return v ? (8'h80 + {4'h0, k}) : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Drive a code-register read for one edge. The data is checked before the edge.
  task automatic read_code(input string req, input logic [7:0] exp);
    cs = 1'b1; rd = 1'b1; addr = 2'd0;
    #0.5 check(req, rdata, exp);
    step();
    cs = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R1 irq in reset", {7'd0, irq_n}, 8'h01);
    rst = 1'b0;
    step();
    check("R1 irq after reset", {7'd0, irq_n}, 8'h01);
    check("R11 idle rdata", rdata, 8'h00);
    read_code("R1 code after reset", 8'h00);

    // Table walk: R2, R3, R4, R6.
    for (int v = 0; v < 10; v++) begin
      key_i = VEC[v][13:4];
      step();
      check("R2 irq asserted", {7'd0, irq_n}, 8'h00);
      check("R3/R4 code", ref_byte(1'b1, ref_key(VEC[v][13:4])), {4'h8, VEC[v][3:0]});
      read_code("R3/R4 read", ref_byte(1'b1, ref_key(VEC[v][13:4])));
      key_i = '0;
      check("R6 irq released", {7'd0, irq_n}, 8'h01);
      read_code("R6 read after clear", 8'h00);
    end

    // R5: a later press is ignored while a code is waiting.
    key_i = 10'h040; step();
    key_i = 10'h042; step();
    check("R5 irq held", {7'd0, irq_n}, 8'h00);
    read_code("R5 code kept", 8'h86);
    key_i = '0; step();
    check("R5 no requeue", {7'd0, irq_n}, 8'h01);

    // R7 and R11: foreign address, and a strobe without chip select.
    key_i = 10'h200; step();
    cs = 1'b1; rd = 1'b1; addr = 2'd1;
    #0.5 check("R7 other address", rdata, 8'h00);
    step();
    cs = 1'b0; addr = 2'd0;
    #0.5 check("R11 rd without cs", rdata, 8'h00);
    step();
    rd = 1'b0;
    check("R7 irq still low", {7'd0, irq_n}, 8'h00);
    read_code("R7 code intact", 8'h89);
    key_i = '0; step();

    // R8: a key held across the clear is not latched again.
    key_i = 10'h004; step();
    read_code("R8 first read", 8'h82);
    step(); step();
    check("R8 held not relatched", {7'd0, irq_n}, 8'h01);
    key_i = '0; step();
    key_i = 10'h004; step();
    check("R8 repress irq", {7'd0, irq_n}, 8'h00);
    read_code("R8 repress code", 8'h82);
    key_i = '0; step();

    // R10: a press arrives in the same cycle as the clearing read.
    key_i = 10'h100; step();
    key_i = 10'h108; cs = 1'b1; rd = 1'b1; addr = 2'd0;
    #0.5 check("R10 old code read", rdata, 8'h88);
    step();
    cs = 1'b0; rd = 1'b0;
    check("R10 irq stays low", {7'd0, irq_n}, 8'h00);
    read_code("R10 new code", 8'h83);
    key_i = '0; step();

    // R9: a key held through reset does not count as a press.
    key_i = 10'h010; rst = 1'b1;
    step(); step();
    rst = 1'b0;
    step(); step();
    check("R9 irq after reset", {7'd0, irq_n}, 8'h01);
    read_code("R9 no code", 8'h00);
    key_i = '0; step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule